// File: doc/BRIEF.md
# Indirect Configuration and Port Access Bridge

This block sits behind a host register port and turns host accesses into single cycles on a downstream request/response port. Software first loads a 32-bit target token into an address register. It then touches one of two data windows. A touch of the configuration window starts a configuration cycle, and a touch of the I/O window starts an I/O-port cycle. Whether the access is a read or a write decides the direction of that cycle.

The two low host address bits and the access size choose the byte lanes. The host holds its request until the bridge raises a one-cycle ready pulse. For a data-window access, that pulse comes only after the downstream side has acknowledged. Downstream errors on reads come back as all ones.

Software brackets every configuration write with a realignment step. It writes the token with its low byte cleared, makes a throwaway configuration read, and then writes the full token. The bridge treats each of these steps as an ordinary access, so the step adds no extra cycle and leaves no stale state behind.

Top module: `idxb_bridge`

## Requirements
- R1: A host write to offset 0x064 loads all 32 bits of `h_wdata` into the address register, whatever the size. A read of 0x064 returns that value. Neither access produces a downstream cycle. The register resets to zero.
- R2: Any access within the word at offset 0x068 produces exactly one downstream cycle. A read gives `d_type` 0 and a write gives `d_type` 1. `d_addr` equals the address register with bits 1:0 forced to zero.
- R3: Any access within the word at offset 0x06C produces exactly one downstream cycle. A read gives `d_type` 2 and a write gives `d_type` 3. `d_addr` is bits 15:0 of the address register, zero-extended.
- R4: Byte enables depend on `h_size`. A byte access (0) gives `1 << h_addr[1:0]`. A halfword access (1) gives `4'b0011` when `h_addr[1]` is 0 and `4'b1100` when it is 1. A word access (2 or 3) gives `4'b1111`.
- R5: On writes, `d_wdata` is the low byte, low halfword or full word of `h_wdata`, as the size selects, shifted up to the lane given by R4. All other bits are zero.
- R6: On a successful read, `h_rdata` is the selected lane of `d_rdata` shifted down to bit 0, with the bits above the access size cleared. Data-window writes return zero.
- R7: A downstream read that completes with `d_err` high returns `32'hFFFFFFFF` on `h_rdata`.
- R8: The bridge raises `h_ready` for exactly one cycle. For a data-window access, it rises in the cycle after the one where `d_ack` is sampled. For any other access, it rises in the cycle after the request is taken. While `d_req` waits for `d_ack`, its fields stay stable and `h_ready` stays low.
- R9: Consider the realignment sequence: write the token with its low byte cleared, make a configuration read, write the full token, then make a configuration write. It yields exactly two downstream cycles. The first is a configuration read at the cleared-byte token. The second is a configuration write at the full token. The read leaves the address register unchanged.
- R10: Accesses to any other offset produce no downstream cycle. They return zero on reads, and their writes leave the address register unchanged.
- R11: After reset, `d_req` and `h_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_req | input | 1 | Host access request, held until `h_ready` |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | AW (12) | Host byte offset |
| h_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| h_wdata | input | 32 | Host write data, right-justified |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| d_req | output | 1 | Downstream cycle request, held until `d_ack` |
| d_type | output | 2 | 0 cfg read, 1 cfg write, 2 I/O read, 3 I/O write |
| d_addr | output | 32 | Downstream cycle address |
| d_be | output | 4 | Downstream byte enables |
| d_wdata | output | 32 | Downstream write data, lane-aligned |
| d_ack | input | 1 | Downstream completion |
| d_err | input | 1 | Downstream error, sampled with `d_ack` |
| d_rdata | input | 32 | Downstream read data, sampled with `d_ack` |

## Verification
The hardest case to reach from the ports is the realignment bracket around a configuration write. In that case, a real read cycle runs against a partially formed token, and the token then changes again before the write. The bench drives the exact three-step sequence followed by a byte write. It logs every request the downstream model sees and compares the type and address of each logged cycle. It also reads the address register back between the steps. A downstream model answers after a delay that varies from cycle to cycle, so the ready timing is checked against ack latencies of zero, one and two cycles. Error responses are forced by choosing token values that the model flags.

// File: rtl/idxb_pkg.sv
package idxb_pkg;
  // bit 1: I/O window, bit 0: write
  typedef enum logic [1:0] {
    CYC_CFG_RD = 2'd0,
    CYC_CFG_WR = 2'd1,
    CYC_IO_RD  = 2'd2,
    CYC_IO_WR  = 2'd3
  } cyc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } seq_st_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/idxb_token_reg.sv
module idxb_token_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] token
);
  logic [DATA_W-1:0] token_q;
  logic [DATA_W-1:0] token_d;

  always_comb begin
    token_d = token_q;
    if (wr_en) token_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) token_q <= '0;
    else        token_q <= token_d;
  end

  assign token = token_q;

  // R1 / R9 / R10: only an explicit load moves the token
  a_r1_token_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(token_q));
endmodule

// File: rtl/idxb_lane.sv
module idxb_lane import idxb_pkg::*; #(
  parameter  int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LW     = $clog2(NB)
) (
  input  logic [1:0]        size,
  input  logic [LW-1:0]     lane,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_raw,
  input  logic              err,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);
  logic [LW-1:0]     lane_eff;
  logic [NB-1:0]     be_base;
  logic [DATA_W-1:0] mask;
  logic [LW+2:0]     shamt;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        lane_eff = lane;
        be_base  = NB'(1);
      end
      SZ_HALF: begin
        lane_eff = {lane[LW-1:1], 1'b0};
        be_base  = NB'(3);
      end
      default: begin
        lane_eff = '0;
        be_base  = '1;
      end
    endcase
  end

  // per-byte data mask follows the enabled lanes before shifting
  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign mask[8*i +: 8] = {8{be_base[i]}};
  end

  assign shamt     = {lane_eff, 3'b000};
  assign be        = be_base << lane_eff;
  assign wdata_out = (wdata_in & mask) << shamt;
  assign rdata_out = err ? '1 : ((rdata_raw >> shamt) & mask);
endmodule

// File: rtl/idxb_seq.sv
module idxb_seq import idxb_pkg::*; #(
  parameter  int          AW      = 12,
  parameter  int          DATA_W  = 32,
  parameter  int          PORT_W  = 16,
  parameter  logic [11:0] TOK_OFS = 12'h064,
  parameter  logic [11:0] CFG_OFS = 12'h068,
  parameter  logic [11:0] IO_OFS  = 12'h06C,
  localparam int          NB      = DATA_W / 8,
  localparam int          LW      = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [AW-1:0]     h_addr,
  input  logic [1:0]        h_size,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [DATA_W-1:0] token,
  output logic              tok_we,
  output logic              h_ready,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              d_ack,
  input  logic [DATA_W-1:0] lane_rdata,
  output logic              d_req,
  output cyc_t              cyc,
  output logic [DATA_W-1:0] d_addr,
  output logic [1:0]        size_q,
  output logic [LW-1:0]     lane_q,
  output logic [DATA_W-1:0] wdat_q
);
  localparam logic [AW-1:0] TOK_A = AW'(TOK_OFS);
  localparam logic [AW-1:0] CFG_A = AW'(CFG_OFS);
  localparam logic [AW-1:0] IO_A  = AW'(IO_OFS);

  seq_st_t           st_q, st_d;
  cyc_t              cyc_q, cyc_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              launch, cap;
  logic              hit_tok, hit_cfg, hit_io;

  assign hit_tok = h_addr[AW-1:LW] == TOK_A[AW-1:LW];
  assign hit_cfg = h_addr[AW-1:LW] == CFG_A[AW-1:LW];
  assign hit_io  = h_addr[AW-1:LW] == IO_A[AW-1:LW];

  always_comb begin
    cyc_d  = cyc_t'({hit_io, h_we});
    addr_d = hit_io ? {{(DATA_W-PORT_W){1'b0}}, token[PORT_W-1:0]}
                    : {token[DATA_W-1:LW], {LW{1'b0}}};
  end

  always_comb begin
    st_d    = st_q;
    launch  = 1'b0;
    cap     = 1'b0;
    tok_we  = 1'b0;
    rdata_d = rdata_q;
    case (st_q)
      ST_IDLE: begin
        if (h_req) begin
          if (hit_cfg || hit_io) begin
            launch = 1'b1;
            st_d   = ST_WAIT;
          end else begin
            cap     = 1'b1;
            tok_we  = hit_tok && h_we;
            rdata_d = (hit_tok && !h_we) ? token : '0;
            st_d    = ST_RESP;
          end
        end
      end
      ST_WAIT: begin
        if (d_ack) begin
          cap     = 1'b1;
          rdata_d = cyc_q[0] ? '0 : lane_rdata;
          st_d    = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CYC_CFG_RD;
      addr_q <= '0;
      size_q <= '0;
      lane_q <= '0;
      wdat_q <= '0;
    end else if (launch) begin
      cyc_q  <= cyc_d;
      addr_q <= addr_d;
      size_q <= h_size;
      lane_q <= h_addr[LW-1:0];
      wdat_q <= h_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= rdata_d;
  end

  assign h_ready = st_q == ST_RESP;
  assign h_rdata = rdata_q;
  assign d_req   = st_q == ST_WAIT;
  assign cyc     = cyc_q;
  assign d_addr  = addr_q;

  // R8: completion follows the downstream ack by one cycle
  a_r8_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && d_ack |=> h_ready);
  // R8: a waiting cycle never completes by itself
  a_r8_wait_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && !d_ack |=> d_req);
endmodule

// File: rtl/idxb_bridge.sv
module idxb_bridge import idxb_pkg::*; #(
  parameter  int AW     = 12,
  parameter  int DATA_W = 32,
  parameter  int PORT_W = 16,
  localparam int NB     = DATA_W / 8,
  localparam int LW     = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [AW-1:0]     h_addr,
  input  logic [1:0]        h_size,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_ready,
  output logic [DATA_W-1:0] h_rdata,
  output logic              d_req,
  output logic [1:0]        d_type,
  output logic [DATA_W-1:0] d_addr,
  output logic [NB-1:0]     d_be,
  output logic [DATA_W-1:0] d_wdata,
  input  logic              d_ack,
  input  logic              d_err,
  input  logic [DATA_W-1:0] d_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              tok_we;
  logic [DATA_W-1:0] token;
  logic [DATA_W-1:0] lane_rdata;
  logic [1:0]        size_q;
  logic [LW-1:0]     lane_q;
  logic [DATA_W-1:0] wdat_q;
  cyc_t              cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  idxb_token_reg #(.DATA_W(DATA_W)) u_tok (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (tok_we),
    .wr_data (h_wdata),
    .token   (token)
  );

  idxb_seq #(.AW(AW), .DATA_W(DATA_W), .PORT_W(PORT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .h_req      (h_req),
    .h_we       (h_we),
    .h_addr     (h_addr),
    .h_size     (h_size),
    .h_wdata    (h_wdata),
    .token      (token),
    .tok_we     (tok_we),
    .h_ready    (h_ready),
    .h_rdata    (h_rdata),
    .d_ack      (d_ack),
    .lane_rdata (lane_rdata),
    .d_req      (d_req),
    .cyc        (cyc),
    .d_addr     (d_addr),
    .size_q     (size_q),
    .lane_q     (lane_q),
    .wdat_q     (wdat_q)
  );

  idxb_lane #(.DATA_W(DATA_W)) u_lane (
    .size      (size_q),
    .lane      (lane_q),
    .wdata_in  (wdat_q),
    .rdata_raw (d_rdata),
    .err       (d_err),
    .be        (d_be),
    .wdata_out (d_wdata),
    .rdata_out (lane_rdata)
  );

  assign d_type = cyc;

  // R8: request fields frozen while waiting
  a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n_s)
    d_req && !d_ack |=> $stable(d_addr) && $stable(d_type) && $stable(d_be) && $stable(d_wdata));
  // R8: ready is a single-cycle pulse and never overlaps a request
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    h_ready |=> !h_ready);
  a_r8_no_ready_in_req: assert property (@(posedge clk) disable iff (!rst_n_s)
    d_req |-> !h_ready);
  // R4: enables form a byte, a halfword or a word
  a_r4_be_shape: assert property (@(posedge clk) disable iff (!rst_n_s)
    d_req |-> ($countones(d_be) == 1 || $countones(d_be) == 2 || $countones(d_be) == 4));
  // R3: port cycles carry no upper address bits
  a_r3_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    d_req && d_type[1] |-> d_addr[DATA_W-1:PORT_W] == '0);
  // R2: configuration cycles are word aligned
  a_r2_cfg_aligned: assert property (@(posedge clk) disable iff (!rst_n_s)
    d_req && !d_type[1] |-> d_addr[LW-1:0] == '0);
endmodule

// File: tb/idxb_bridge_bench.sv
`timescale 1ns/1ps
module idxb_bridge_bench;
  logic        clk;
  logic        rst_n;
  logic        h_req, h_we;
  logic [11:0] h_addr;
  logic [1:0]  h_size;
  logic [31:0] h_wdata;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic        d_req;
  logic [1:0]  d_type;
  logic [31:0] d_addr;
  logic [3:0]  d_be;
  logic [31:0] d_wdata;
  logic        d_ack, d_err;
  logic [31:0] d_rdata;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int req_cnt = 0;
  int ack_cyc = 0;
  logic [1:0]  last_type;
  logic [31:0] last_addr;
  logic [3:0]  last_be;
  logic [31:0] last_wdata;

  idxb_bridge u_idxb_bridge (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
    .d_req(d_req), .d_type(d_type), .d_addr(d_addr), .d_be(d_be),
    .d_wdata(d_wdata), .d_ack(d_ack), .d_err(d_err), .d_rdata(d_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rsp(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[7:0] ^ 8'hC3, a[15:8] + 8'h11};
  endfunction

  function automatic logic is_err(input logic [1:0] t, input logic [31:0] a);
    return t[1] ? (a[15:8] == 8'hFE) : (a[23:16] == 8'hEE);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // downstream model: variable delay, records each new request
  initial begin
    automatic logic seen = 1'b0;
    automatic int   wcnt = 0;
    automatic int   dly  = 0;
    d_ack = 1'b0; d_err = 1'b0; d_rdata = '0;
    forever begin
      @(negedge clk);
      if (d_ack) begin
        d_ack = 1'b0;
        d_err = 1'b0;
      end else if (d_req) begin
        if (!seen) begin
          seen = 1'b1;
          req_cnt++;
          last_type = d_type; last_addr = d_addr;
          last_be = d_be; last_wdata = d_wdata;
          wcnt = 0;
          dly = req_cnt % 3;
        end
        if (wcnt >= dly) begin
          d_ack   = 1'b1;
          d_err   = is_err(last_type, last_addr);
          d_rdata = rsp(last_addr);
          ack_cyc = cyc;
          seen    = 1'b0;
        end else wcnt++;
      end
    end
  end

  task automatic host(input logic we, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output int rcyc);
    automatic int n = 0;
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_size = sz; h_wdata = wd;
    do begin
      @(negedge clk);
      n++;
    end while (!h_ready && n < 2000);
    if (!h_ready) chk("R8 ready timeout", 32'd0, 32'd1);
    rd   = h_rdata;
    rcyc = cyc;
    h_req = 1'b0;
    @(negedge clk);
    chk("R8 ready single pulse", {31'd0, h_ready}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    automatic logic [31:0] rd;
    automatic int rc;
    automatic int n0;
    h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_size = '0; h_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 d_req after reset", {31'd0, d_req}, 32'd0);
    chk("R11 h_ready after reset", {31'd0, h_ready}, 32'd0);
    host(1'b0, 12'h064, 2'd2, 32'd0, rd, rc);
    chk("R1 token reset value", rd, 32'd0);

    // R2..R6, R8 sweep over windows, directions, sizes and lanes
    for (int win = 0; win < 2; win++)
      for (int we = 0; we < 2; we++)
        for (int sz = 0; sz < 3; sz++)
          for (int lo = 0; lo < 4; lo++) begin
            automatic logic [31:0] tok;
            automatic logic [31:0] wd;
            automatic logic [31:0] ea;
            automatic logic [31:0] mask;
            automatic int          sh;
            automatic string       rq;
            int ic;
            rq = (win == 1) ? "R3" : "R2";
            tok = (win == 0) ? {8'h00, 8'(8'h01 + lo), 8'(8'h20 + sz), 8'h40}
                             : {16'hABCD, 8'h12, 8'(8'h30 + lo * 4)};
            n0 = req_cnt;
            host(1'b1, 12'h064, 2'(sz), tok, rd, ic);
            chk("R1 token write makes no cycle", 32'(req_cnt), 32'(n0));
            host(1'b0, 12'h064, 2'd2, 32'd0, rd, ic);
            chk("R1 token readback", rd, tok);
            wd = 32'h9E3779B9 + 32'(lo) * 32'h01010101 + 32'(sz);
            ea = (win == 1) ? {16'h0, tok[15:0]} : tok;
            mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFFFFFF;
            sh   = (sz == 0) ? lo * 8 : (sz == 1) ? (lo / 2) * 16 : 0;
            n0 = req_cnt;
            host(1'(we), (win == 1 ? 12'h06C : 12'h068) + 12'(lo), 2'(sz), wd, rd, rc);
            chk({rq, " one cycle"}, 32'(req_cnt), 32'(n0 + 1));
            chk({rq, " cycle type"}, {30'd0, last_type}, 32'(win * 2 + we));
            chk({rq, " cycle address"}, last_addr, ea);
            chk("R4 byte enables", {28'd0, last_be},
                (sz == 0) ? 32'(1 << lo) : (sz == 1) ? 32'(3 << ((lo / 2) * 2)) : 32'hF);
            chk("R8 ready after ack", 32'(rc), 32'(ack_cyc + 1));
            if (we == 1) begin
              chk("R5 write data lanes", last_wdata, (wd & mask) << sh);
              chk("R6 write returns zero", rd, 32'd0);
            end else
              chk("R6 read data extract", rd, (rsp(ea) >> sh) & mask);
          end

    // R7 error responses
    host(1'b1, 12'h064, 2'd2, 32'h00EE0844, rd, rc);
    host(1'b0, 12'h069, 2'd0, 32'd0, rd, rc);
    chk("R7 cfg error reads all ones", rd, 32'hFFFFFFFF);
    host(1'b1, 12'h064, 2'd2, 32'h0000FE10, rd, rc);
    host(1'b0, 12'h06E, 2'd1, 32'd0, rd, rc);
    chk("R7 io error reads all ones", rd, 32'hFFFFFFFF);

    // R9 realignment bracket around a configuration write
    n0 = req_cnt;
    host(1'b1, 12'h064, 2'd2, 32'h0003184C & 32'hFFFFFF00, rd, rc);
    host(1'b0, 12'h068, 2'd2, 32'd0, rd, rc);
    chk("R9 dummy read type", {30'd0, last_type}, 32'd0);
    chk("R9 dummy read address", last_addr, 32'h00031800);
    chk("R9 dummy read data", rd, rsp(32'h00031800));
    host(1'b0, 12'h064, 2'd2, 32'd0, rd, rc);
    chk("R9 token kept across dummy read", rd, 32'h00031800);
    host(1'b1, 12'h064, 2'd2, 32'h0003184C, rd, rc);
    host(1'b1, 12'h06A, 2'd0, 32'h0000005A, rd, rc);
    chk("R9 write type", {30'd0, last_type}, 32'd1);
    chk("R9 write address", last_addr, 32'h0003184C);
    chk("R9 write enables", {28'd0, last_be}, 32'h4);
    chk("R9 write data", last_wdata, 32'h005A0000);
    chk("R9 cycle count", 32'(req_cnt), 32'(n0 + 2));

    // R10 unmapped offsets
    n0 = req_cnt;
    host(1'b1, 12'h070, 2'd2, 32'hDEADBEEF, rd, rc);
    host(1'b0, 12'h000, 2'd2, 32'd0, rd, rc);
    chk("R10 unmapped read zero", rd, 32'd0);
    host(1'b1, 12'h060, 2'd2, 32'h12345678, rd, rc);
    chk("R10 no cycle", 32'(req_cnt), 32'(n0));
    host(1'b0, 12'h064, 2'd2, 32'd0, rd, rc);
    chk("R10 token untouched", rd, 32'h0003184C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule